// File: doc/BRIEF.md
# Flash Chip-Erase Command Decoder

This block is the write-side command front end of a 16-bit-word NOR flash model, together with the internal engine that carries out a whole-array erase. The host issues plain bus writes, each a word address plus a data word. The decoder follows them through a fixed six-write unlock and confirm sequence. Only the exact sequence starts the erase. A wrong address, a wrong data word, or the reset-to-read word sends the decoder back to its first step.

Once started, the engine works without any help from the host. It first writes zero to every word of a small parameterised array and reads each one back to confirm the zero. It then sets every word to all ones. Each pass moves one word per clock. A configurable hold count after the verify pass and after the erase pass stands in for erase time. While the engine is busy, reads return a status word instead of array data, and bus writes have no effect. Hardware reset stops the engine at once and puts the model back in read mode. Reset also reloads the modelled array with its power-up pattern.

Top module: `flash_erase_ctrl`

## Requirements
- R1: The erase starts only after this exact run of six accepted writes (address/data, hex): 555/00AA, 2AA/0055, 555/0080, 555/00AA, 2AA/0055, 555/0010. `busy` reads 1 from the clock edge that samples the sixth write.
- R2: A write whose address or data differs from the one expected at the current step returns the decoder to step one, and no erase starts.
- R3: A write of data 00F0, at any address, returns the decoder to step one.
- R4: While `busy` is 1, bus writes change neither the decoder step nor the engine.
- R5: A fault-free erase keeps `busy` at 1 for exactly 3*DEPTH + 2*HOLD_CYCLES clock edges after the sixth write. Afterwards every word reads FFFF and `verify_fail` is 0.
- R6: The engine writes zero to every word before it verifies. If a word read back during the verify pass is not zero (`fault_inj` forces bit 0 of the read-back high), the engine sets `verify_fail` and ends `busy` after DEPTH+1 edges, leaving every word at 0000. The next start clears `verify_fail`.
- R7: While `busy` is 1, `rd_data` is a status word. Bit 7 is 0, bits 6 and 2 both equal a toggle that starts at 0 and flips after each clock edge with `rd_en` high, and all other bits are 0. Successive reads therefore give 0000, 0044, 0000, and so on.
- R8: With `rst_n` low, `busy` and `verify_fail` are 0 and the block is in read mode. Word i then reads A5A5 XOR (i * 0101) (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset; aborts an erase |
| wr_en | input | 1 | Host write strobe, one write per high cycle |
| wr_addr | input | BUS_AW | Word address of the host write |
| wr_data | input | 16 | Data word of the host write |
| rd_en | input | 1 | Read strobe; advances the status toggle while busy |
| rd_addr | input | $clog2(DEPTH) | Array word to read |
| rd_data | output | 16 | Array word when idle, status word when busy |
| busy | output | 1 | Erase engine active |
| verify_fail | output | 1 | Verify pass found a non-zero word |
| fault_inj | input | 1 | Forces a non-zero read-back during the verify pass |

## Verification
`busy` is a register, so it changes at the same edge that samples the sixth write. The bench therefore checks it at the falling edge that follows that write. The end of the erase is timed by a free-running edge counter in the bench. It checks `busy` high exactly 3*DEPTH+2*HOLD_CYCLES-1 edges after the start and low one edge later; a fault ends `busy` at DEPTH+1 edges, and the bench checks it there. `rd_data` is combinational, so status and array reads are compared within the same low clock phase. The toggle is checked before and after each edge that sees `rd_en`. A reset abort is checked a few nanoseconds after `rst_n` falls, with no clock edge in between.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

   localparam int WORD_W  = 16;
   localparam int SEQ_LEN = 6;

   localparam logic [WORD_W-1:0] CMD_TO_READ = 16'h00F0;

   localparam int STAT_DONE_BIT = 7;
   localparam int STAT_TOG_BIT  = 6;
   localparam int STAT_ALT_BIT  = 2;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_ZERO,
      ENG_CHECK,
      ENG_HOLD_A,
      ENG_ONES,
      ENG_HOLD_B
   } eng_state_t;

   // expected address of each step of the erase sequence
   function automatic int unsigned seq_addr(int unsigned step);
      case (step)
         1, 4:    return 32'h2AA;
         default: return 32'h555;
      endcase
   endfunction

   // expected data of each step of the erase sequence
   function automatic logic [WORD_W-1:0] seq_data(int unsigned step);
      case (step)
         0, 3:    return 16'h00AA;
         1, 4:    return 16'h0055;
         2:       return 16'h0080;
         default: return 16'h0010;
      endcase
   endfunction

   // power-up content of the modelled array
   function automatic logic [WORD_W-1:0] init_word(int unsigned idx);
      return 16'hA5A5 ^ WORD_W'(idx * 32'h0101);
   endfunction

endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
   import flash_erase_pkg::*;
#(
   parameter int BUS_AW = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [BUS_AW-1:0]   wr_addr,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic                busy,
   output logic                start
);

   localparam int STEP_W = $clog2(SEQ_LEN);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

   logic [STEP_W-1:0] step;
   logic [BUS_AW-1:0] exp_addr;
   logic              hit;
   logic              at_last;
   logic              take;

   always_comb begin
      exp_addr = BUS_AW'(seq_addr(32'(step)));
      hit      = (wr_addr == exp_addr) && (wr_data == seq_data(32'(step)));
      at_last  = (step == LAST_STEP);
      take     = wr_en && !busy;
      start    = take && hit && at_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= '0;
      end else if (take) begin
         if (wr_data == CMD_TO_READ) begin
            step <= '0;
         end else if (hit) begin
            step <= at_last ? '0 : step + 1'b1;
         end else begin
            step <= '0;
         end
      end
   end

   assert_busy_writes_ignored_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      (busy && wr_en) |=> (step == $past(step)))
      else $error("decoder step moved on a write while busy");

endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
   import flash_erase_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int HOLD_CYCLES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       fault_inj,
   input  logic [$clog2(DEPTH)-1:0]   rd_addr,
   output logic                       busy,
   output logic                       verify_fail,
   output logic [WORD_W-1:0]          array_word
);

   localparam int  IDX_W    = $clog2(DEPTH);
   localparam int  CNT_W    = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
   localparam bit  HAS_HOLD = (HOLD_CYCLES > 0);
   localparam int  HOLD_END = HAS_HOLD ? HOLD_CYCLES - 1 : 0;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   eng_state_t           state;
   logic [IDX_W-1:0]     idx;
   logic [CNT_W-1:0]     hold_cnt;
   logic [WORD_W-1:0]    cells [DEPTH];
   logic [WORD_W-1:0]    readback;
   logic                 last_word;
   logic                 hold_done;
   logic                 cell_we;
   logic [WORD_W-1:0]    cell_val;

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (HOLD_CYCLES < 0) begin : g_bad_hold
      $error("HOLD_CYCLES must not be negative");
   end

   // one storage word per generate slot, loaded with its power-up pattern on reset
   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= init_word(g);
         end else if (cell_we && idx == IDX_W'(g)) begin
            q <= cell_val;
         end
      end
      assign cells[g] = q;
   end

   always_comb begin
      last_word  = (idx == LAST_IDX);
      hold_done  = (hold_cnt == CNT_W'(HOLD_END));
      cell_we    = (state == ENG_ZERO) || (state == ENG_ONES);
      cell_val   = (state == ENG_ONES) ? '1 : '0;
      readback   = cells[idx] | {{(WORD_W-1){1'b0}}, fault_inj};
      array_word = cells[rd_addr];
      busy       = (state != ENG_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ENG_IDLE;
         idx         <= '0;
         hold_cnt    <= '0;
         verify_fail <= 1'b0;
      end else begin
         case (state)
            ENG_IDLE: begin
               if (start) begin
                  state       <= ENG_ZERO;
                  idx         <= '0;
                  verify_fail <= 1'b0;
               end
            end
            ENG_ZERO: begin
               idx <= last_word ? '0 : idx + 1'b1;
               if (last_word) state <= ENG_CHECK;
            end
            ENG_CHECK: begin
               if (readback != '0) begin
                  verify_fail <= 1'b1;
                  state       <= ENG_IDLE;
                  idx         <= '0;
               end else begin
                  idx <= last_word ? '0 : idx + 1'b1;
                  if (last_word) begin
                     state    <= HAS_HOLD ? ENG_HOLD_A : ENG_ONES;
                     hold_cnt <= '0;
                  end
               end
            end
            ENG_HOLD_A: begin
               hold_cnt <= hold_cnt + 1'b1;
               if (hold_done) begin
                  state    <= ENG_ONES;
                  hold_cnt <= '0;
               end
            end
            ENG_ONES: begin
               idx <= last_word ? '0 : idx + 1'b1;
               if (last_word) begin
                  state    <= HAS_HOLD ? ENG_HOLD_B : ENG_IDLE;
                  hold_cnt <= '0;
               end
            end
            ENG_HOLD_B: begin
               hold_cnt <= hold_cnt + 1'b1;
               if (hold_done) begin
                  state    <= ENG_IDLE;
                  hold_cnt <= '0;
               end
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   assert_start_sets_busy_R1: assert property (
      @(posedge clk) disable iff (!rst_n)
      start |=> busy)
      else $error("start was not followed by busy");

   assert_fail_ends_busy_R6: assert property (
      @(posedge clk) disable iff (!rst_n)
      $rose(verify_fail) |-> !busy)
      else $error("verify failure left the engine busy");

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import flash_erase_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                busy,
   input  logic                start,
   input  logic                rd_en,
   input  logic [WORD_W-1:0]   array_word,
   output logic [WORD_W-1:0]   rd_data
);

   logic toggle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         toggle <= 1'b0;
      end else if (start) begin
         toggle <= 1'b0;
      end else if (busy && rd_en) begin
         toggle <= ~toggle;
      end
   end

   always_comb begin
      if (busy) begin
         rd_data                = '0;
         rd_data[STAT_DONE_BIT] = 1'b0;
         rd_data[STAT_TOG_BIT]  = toggle;
         rd_data[STAT_ALT_BIT]  = toggle;
      end else begin
         rd_data = array_word;
      end
   end

   assert_toggle_per_read_R7: assert property (
      @(posedge clk) disable iff (!rst_n)
      (busy && rd_en) |=> (!busy || rd_data[STAT_TOG_BIT] != $past(rd_data[STAT_TOG_BIT])))
      else $error("status toggle bit did not flip on a busy read");

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
   import flash_erase_pkg::*;
#(
   parameter int BUS_AW      = 12,
   parameter int DEPTH       = 16,
   parameter int HOLD_CYCLES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [BUS_AW-1:0]          wr_addr,
   input  logic [15:0]                wr_data,
   input  logic                       rd_en,
   input  logic [$clog2(DEPTH)-1:0]   rd_addr,
   output logic [15:0]                rd_data,
   output logic                       busy,
   output logic                       verify_fail,
   input  logic                       fault_inj
);

   if (BUS_AW < 11) begin : g_bad_aw
      $error("BUS_AW must hold word address 0x555");
   end

   logic              start;
   logic [WORD_W-1:0] array_word;

   flash_seq_decoder #(
      .BUS_AW (BUS_AW)
   ) u_decoder (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .busy    (busy),
      .start   (start)
   );

   flash_erase_engine #(
      .DEPTH       (DEPTH),
      .HOLD_CYCLES (HOLD_CYCLES)
   ) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .fault_inj   (fault_inj),
      .rd_addr     (rd_addr),
      .busy        (busy),
      .verify_fail (verify_fail),
      .array_word  (array_word)
   );

   flash_status_gen u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy),
      .start      (start),
      .rd_en      (rd_en),
      .array_word (array_word),
      .rd_data    (rd_data)
   );

   assert_busy_after_write_R1: assert property (
      @(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_en))
      else $error("busy rose without a host write");

endmodule

// File: tb/flash_erase_ctrl_test.sv
module flash_erase_ctrl_test;

   localparam int BUS_AW = 12;
   localparam int DEPTH  = 16;
   localparam int HOLD   = 4;
   localparam int AW     = $clog2(DEPTH);
   localparam int T_FULL = 3 * DEPTH + 2 * HOLD;
   localparam int NVEC   = 22;

   // {address, data, expected busy after the write}
   localparam logic [28:0] VEC [NVEC] = '{
      {12'h555, 16'h00AA, 1'b0}, {12'h2AA, 16'h0055, 1'b0}, {12'h555, 16'h0080, 1'b0},
      {12'h555, 16'h00AA, 1'b0}, {12'h2AA, 16'h0055, 1'b0}, {12'h555, 16'h0011, 1'b0},
      {12'h555, 16'h00AA, 1'b0}, {12'h2AA, 16'h0055, 1'b0}, {12'h2AA, 16'h0080, 1'b0},
      {12'h555, 16'h00AA, 1'b0}, {12'h2AA, 16'h0055, 1'b0}, {12'h555, 16'h0080, 1'b0},
      {12'h555, 16'h00AA, 1'b0}, {12'h123, 16'h00F0, 1'b0}, {12'h2AA, 16'h0055, 1'b0},
      {12'h555, 16'h0010, 1'b0},
      {12'h555, 16'h00AA, 1'b0}, {12'h2AA, 16'h0055, 1'b0}, {12'h555, 16'h0080, 1'b0},
      {12'h555, 16'h00AA, 1'b0}, {12'h2AA, 16'h0055, 1'b0}, {12'h555, 16'h0010, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              wr_en;
   logic [BUS_AW-1:0] wr_addr;
   logic [15:0]       wr_data;
   logic              rd_en;
   logic [AW-1:0]     rd_addr;
   logic [15:0]       rd_data;
   logic              busy;
   logic              verify_fail;
   logic              fault_inj;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int start_cyc;

   flash_erase_ctrl #(
      .BUS_AW      (BUS_AW),
      .DEPTH       (DEPTH),
      .HOLD_CYCLES (HOLD)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rd_en       (rd_en),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .busy        (busy),
      .verify_fail (verify_fail),
      .fault_inj   (fault_inj)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] exp_init(int i);
      return 16'hA5A5 ^ 16'(i * 257);
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [BUS_AW-1:0] a, logic [15:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic full_seq();
      wr(12'h555, 16'h00AA);
      wr(12'h2AA, 16'h0055);
      wr(12'h555, 16'h0080);
      wr(12'h555, 16'h00AA);
      wr(12'h2AA, 16'h0055);
      wr(12'h555, 16'h0010);
      start_cyc = cyc;
   endtask

   task automatic wait_edges(int k);
      while (cyc < start_cyc + k) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      rd_en = 1'b0; rd_addr = '0; fault_inj = 1'b0;
      repeat (3) @(negedge clk);
      // R8 reset state
      chk("R8 busy in reset", 16'(busy), 16'h0);
      chk("R8 verify_fail in reset", 16'(verify_fail), 16'h0);
      chk("R8 word 0 in reset", rd_data, exp_init(0));
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 vector table
      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][28:17], VEC[i][16:1]);
         chk(i == NVEC - 1 ? "R1 busy after sequence" : "R2/R3 no start",
             16'(busy), 16'(VEC[i][0]));
      end
      start_cyc = cyc;

      // R7 status toggling
      rd_en = 1'b1; #1;
      chk("R7 first status read", rd_data, 16'h0000);
      @(negedge clk); #1;
      chk("R7 second status read", rd_data, 16'h0044);
      rd_en = 1'b0;
      @(negedge clk);
      rd_en = 1'b1; #1;
      chk("R7 third status read", rd_data, 16'h0044);
      @(negedge clk); #1;
      chk("R7 fourth status read", rd_data, 16'h0000);
      rd_en = 1'b0;
      @(negedge clk);

      // R4 write during busy must not count as step one
      wr(12'h555, 16'h00AA);

      // R5 busy window
      wait_edges(T_FULL - 1);
      chk("R5 busy before end", 16'(busy), 16'h1);
      @(negedge clk);
      chk("R5 busy at end", 16'(busy), 16'h0);
      chk("R5 no verify failure", 16'(verify_fail), 16'h0);
      for (int w = 0; w < DEPTH; w++) begin
         rd_addr = AW'(w); #1;
         chk("R5 erased word", rd_data, 16'hFFFF);
      end
      @(negedge clk);

      // R4 the rest of a sequence whose first write came while busy
      wr(12'h2AA, 16'h0055);
      wr(12'h555, 16'h0080);
      wr(12'h555, 16'h00AA);
      wr(12'h2AA, 16'h0055);
      wr(12'h555, 16'h0010);
      chk("R4 busy write ignored", 16'(busy), 16'h0);

      // R6 verify fault
      fault_inj = 1'b1;
      full_seq();
      wait_edges(DEPTH);
      chk("R6 busy through zero pass", 16'(busy), 16'h1);
      @(negedge clk);
      chk("R6 busy after fault", 16'(busy), 16'h0);
      chk("R6 verify_fail set", 16'(verify_fail), 16'h1);
      fault_inj = 1'b0;
      for (int w = 0; w < DEPTH; w++) begin
         rd_addr = AW'(w); #1;
         chk("R6 preprogrammed word", rd_data, 16'h0000);
      end
      @(negedge clk);

      // R6 restart clears flag, then R8 abort by reset
      full_seq();
      chk("R6 verify_fail cleared", 16'(verify_fail), 16'h0);
      chk("R1 restart busy", 16'(busy), 16'h1);
      repeat (5) @(negedge clk);
      rst_n = 1'b0; rd_addr = AW'(3); #2;
      chk("R8 abort busy", 16'(busy), 16'h0);
      chk("R8 abort read mode", rd_data, exp_init(3));
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      full_seq();
      chk("R1 start after abort", 16'(busy), 16'h1);

      finish_run();
   end

endmodule